// File: doc/BRIEF.md
# TPM SPI Wait-State Transaction Engine

This block is a half-duplex SPI host that carries out a complete TPM register access in hardware. A single request from the host side names the direction, a 16-bit register address and a byte count. The engine then sends a four-byte header, handles any flow-control wait that the target inserts, and moves the data bytes. Requests longer than one frame are cut into several frames. Each frame has its own header and all of them use the same register address.

The target asks for a wait by the level it puts on MISO while the host shifts out the final address bit. The engine samples MISO in that bit and stalls in hardware. During the stall it clocks poll bytes until the target reports ready, and only then starts the data phase. Software therefore never needs full-duplex access to see the wait. A limit on the number of poll bytes ends a wait that never completes. A request that asks for flow handling on a bus without poll capability is refused without touching the bus.

Top module: `tpm_spi_wait_engine`

## Requirements
- R1: Header byte 0 of every frame carries 1 in bit 7 for a read and 0 for a write, 0 in bit 6, and the frame's byte count minus one in bits 5:0.
- R2: Header bytes 1, 2 and 3 are 0xD4, address bits 15:8 and address bits 7:0. Every byte is shifted MSB first in SPI mode 0: MOSI is stable while SCK is low, and MISO is sampled on the SCK rising edge.
- R3: cs_n is high and sck is low whenever no frame is in progress. Within one frame, cs_n stays low from the first header bit to the last data bit. The frame holds exactly 32 header bits, then any poll bytes, then eight bits per data byte.
- R4: A request longer than 64 bytes is sent as consecutive frames. Every frame except the last carries 64 bytes, the last carries the rest, and cs_n goes high between frames.
- R5: When poll handling is armed and MISO is low in the last address bit, the engine sends poll bytes with MOSI held low. It stops after the first received poll byte whose bit 0 is 1, and the data phase starts on the next byte.
- R6: When MISO is high in the last address bit, the data phase starts directly after the address bytes, with no poll byte.
- R7: When poll_limit poll bytes have been sent without a ready byte, cs_n is released and done is raised with status 2. Any frames not yet sent are abandoned. A limit of 0 times out right after the header. A ready byte that arrives exactly at the limit is accepted.
- R8: The data phase is half duplex. On a read, MOSI stays low and every received byte is presented on rd_data with a one-cycle rd_valid pulse. On a write, one wr_take pulse takes each byte of wr_data, and rd_valid never pulses.
- R9: A request with req_flow set while cap_wait_poll is low is answered on the next cycle with done and status 1, and cs_n never goes low.
- R10: An accepted request with req_flow set arms poll handling (poll_armed = 1). A request with req_flow clear disarms it, and for that request the MISO level in the last address bit is ignored.
- R11: A request with a byte count of 0 is answered on the next cycle with done and status 0, and causes no bus activity.
- R12: Reset forces cs_n high, sck low, done low, poll_armed low and req_ready high. This holds even when reset arrives in the middle of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken while req_ready is high |
| req_ready | output | 1 | Engine idle and able to take a request |
| req_read | input | 1 | 1 = read, 0 = write |
| req_flow | input | 1 | Request asks for wait-state handling |
| req_addr | input | 16 | Register address |
| req_len | input | LEN_W | Total byte count |
| wr_data | input | 8 | Next write byte |
| wr_take | output | 1 | Pulse: wr_data has been taken |
| rd_data | output | 8 | Received read byte |
| rd_valid | output | 1 | Pulse: rd_data holds a new byte |
| cap_wait_poll | input | 1 | Bus-side poll capability present |
| poll_limit | input | LIM_W | Maximum number of poll bytes per frame |
| poll_armed | output | 1 | Wait-state handling is armed |
| done | output | 1 | Pulse: request finished |
| status | output | 2 | 0 ok, 1 no capability, 2 poll timeout; valid with done |
| sck | output | 1 | SPI clock, idles low |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Host-to-target data |
| miso | input | 1 | Target-to-host data |

## Verification
The assertions check the following on every cycle:
- the bus parks correctly between frames;
- each frame starts with SCK low in the header phase;
- MOSI stays low during poll bytes and read data;
- write-data takes never happen on a read;
- the poll count stays within its limit;
- refused and zero-length requests get their one-cycle answers.

Other properties depend on a target that actually answers, so only the bench's modelled target can show them. These are the header contents, frame splitting, the exact frame lengths with and without waits, the round-trip data, the boundary where a ready byte meets the limit, and the arming and disarming of poll handling across requests.

// File: rtl/tpm_spi_wait_engine.sv
module tpm_spi_wait_engine #(
  parameter int MAX_FRAME = 64,
  parameter int LEN_W     = 12,
  parameter int LIM_W     = 8,
  parameter int HALF      = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_read,
  input  logic             req_flow,
  input  logic [15:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  input  logic [7:0]       wr_data,
  output logic             wr_take,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  input  logic             cap_wait_poll,
  input  logic [LIM_W-1:0] poll_limit,
  output logic             poll_armed,
  output logic             done,
  output logic [1:0]       status,
  output logic             sck,
  output logic             cs_n,
  output logic             mosi,
  input  logic             miso
);

  localparam int CNT_W = $clog2(MAX_FRAME);
  localparam int FS_W  = CNT_W + 1;
  localparam int DIV_W = $clog2(HALF) + 1;
  localparam logic [1:0] ST_OK = 2'd0, ST_NOCAP = 2'd1, ST_TIMEOUT = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_XFER, S_GAP} state_t;
  typedef enum logic [1:0] {P_HDR, P_POLL, P_DATA} phase_t;

  state_t           state;
  phase_t           phase;
  logic [1:0]       hdr_idx;
  logic [2:0]       bit_cnt;
  logic [DIV_W-1:0] div_cnt;
  logic             sck_r, cs_n_r;
  logic [7:0]       tx_sh, rx_sh;
  logic [LEN_W-1:0] rem;
  logic [FS_W-1:0]  dleft;
  logic [LIM_W-1:0] poll_cnt, lim_r;
  logic             rd_r;
  logic [15:0]      addr_r;
  logic             armed_r, done_r, rd_valid_r, wr_take_r;
  logic [1:0]       status_r;
  logic [7:0]       rd_data_r;

  logic             tick, refuse, launch, capture_en, next_rd;
  logic [LEN_W-1:0] src_len;
  logic [FS_W-1:0]  next_fs, fs_m1;
  logic [7:0]       hdr0, hdr_next, data_tx;

  assign tick       = (div_cnt == DIV_W'(HALF - 1));
  assign refuse     = req_flow && !cap_wait_poll;
  assign src_len    = (state == S_IDLE) ? req_len : rem;
  assign next_rd    = (state == S_IDLE) ? req_read : rd_r;
  assign next_fs    = (src_len > LEN_W'(MAX_FRAME)) ? FS_W'(MAX_FRAME) : src_len[FS_W-1:0];
  assign fs_m1      = next_fs - FS_W'(1);
  assign hdr0       = {next_rd, {(7-CNT_W){1'b0}}, fs_m1[CNT_W-1:0]};
  assign hdr_next   = (hdr_idx == 2'd0) ? 8'hD4 : (hdr_idx == 2'd1) ? addr_r[15:8] : addr_r[7:0];
  assign data_tx    = rd_r ? 8'h00 : wr_data;
  assign capture_en = !(phase == P_DATA && !rd_r);
  assign launch     = (state == S_IDLE && req_valid && !refuse && req_len != '0) ||
                      (state == S_GAP && tick);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;  phase <= P_HDR;  hdr_idx <= '0;  bit_cnt <= '0;
      div_cnt <= '0;    sck_r <= 1'b0;   cs_n_r <= 1'b1;
      tx_sh <= '0;      rx_sh <= '0;     rem <= '0;      dleft <= '0;
      poll_cnt <= '0;   lim_r <= '0;     rd_r <= 1'b0;   addr_r <= '0;
      armed_r <= 1'b0;  done_r <= 1'b0;  rd_valid_r <= 1'b0;
      wr_take_r <= 1'b0; status_r <= ST_OK; rd_data_r <= '0;
    end else begin
      done_r     <= 1'b0;
      rd_valid_r <= 1'b0;
      wr_take_r  <= 1'b0;
      unique case (state)
        S_IDLE: begin
          div_cnt <= '0;
          sck_r   <= 1'b0;
          if (req_valid) begin
            rd_r   <= req_read;
            addr_r <= req_addr;
            lim_r  <= poll_limit;
            if (refuse) begin
              done_r   <= 1'b1;
              status_r <= ST_NOCAP;
            end else begin
              armed_r <= req_flow;
              if (req_len == '0) begin
                done_r   <= 1'b1;
                status_r <= ST_OK;
              end
            end
          end
        end
        S_GAP: div_cnt <= tick ? '0 : div_cnt + DIV_W'(1);
        S_XFER: begin
          div_cnt <= tick ? '0 : div_cnt + DIV_W'(1);
          if (tick && !sck_r) begin
            sck_r <= 1'b1;
            if (capture_en) rx_sh <= {rx_sh[6:0], miso};
          end else if (tick) begin
            sck_r <= 1'b0;
            if (bit_cnt != 3'd7) begin
              bit_cnt <= bit_cnt + 3'd1;
              tx_sh   <= {tx_sh[6:0], 1'b0};
            end else begin
              bit_cnt <= '0;
              unique case (phase)
                P_HDR: begin
                  if (hdr_idx != 2'd3) begin
                    hdr_idx <= hdr_idx + 2'd1;
                    tx_sh   <= hdr_next;
                  end else if (armed_r && !rx_sh[0]) begin
                    if (lim_r == '0) begin
                      cs_n_r <= 1'b1; state <= S_IDLE; done_r <= 1'b1; status_r <= ST_TIMEOUT;
                    end else begin
                      phase <= P_POLL; poll_cnt <= LIM_W'(1); tx_sh <= '0;
                    end
                  end else begin
                    phase <= P_DATA; tx_sh <= data_tx; wr_take_r <= !rd_r;
                  end
                end
                P_POLL: begin
                  if (rx_sh[0]) begin
                    phase <= P_DATA; tx_sh <= data_tx; wr_take_r <= !rd_r;
                  end else if (poll_cnt == lim_r) begin
                    cs_n_r <= 1'b1; state <= S_IDLE; done_r <= 1'b1; status_r <= ST_TIMEOUT;
                  end else begin
                    poll_cnt <= poll_cnt + LIM_W'(1); tx_sh <= '0;
                  end
                end
                default: begin
                  if (rd_r) begin
                    rd_valid_r <= 1'b1;
                    rd_data_r  <= rx_sh;
                  end
                  dleft <= dleft - FS_W'(1);
                  if (dleft == FS_W'(1)) begin
                    cs_n_r <= 1'b1;
                    if (rem == '0) begin
                      state <= S_IDLE; done_r <= 1'b1; status_r <= ST_OK;
                    end else begin
                      state <= S_GAP;
                    end
                  end else begin
                    tx_sh <= data_tx; wr_take_r <= !rd_r;
                  end
                end
              endcase
            end
          end
        end
        default: state <= S_IDLE;
      endcase
      if (launch) begin
        state   <= S_XFER;
        cs_n_r  <= 1'b0;
        phase   <= P_HDR;
        hdr_idx <= '0;
        bit_cnt <= '0;
        div_cnt <= '0;
        tx_sh   <= hdr0;
        dleft   <= next_fs;
        rem     <= src_len - LEN_W'(next_fs);
      end
    end
  end

  assign req_ready  = (state == S_IDLE);
  assign sck        = sck_r;
  assign cs_n       = cs_n_r;
  assign mosi       = !cs_n_r && tx_sh[7];
  assign poll_armed = armed_r;
  assign done       = done_r;
  assign status     = status_r;
  assign rd_valid   = rd_valid_r;
  assign rd_data    = rd_data_r;
  assign wr_take    = wr_take_r;

endmodule

// File: rtl/tpm_spi_wait_engine_chk.sv
module tpm_spi_wait_engine_chk #(
  parameter int LEN_W = 12,
  parameter int LIM_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic             req_flow,
  input logic [LEN_W-1:0] req_len,
  input logic             cap_wait_poll,
  input logic             done,
  input logic [1:0]       status,
  input logic             sck,
  input logic             cs_n,
  input logic             mosi,
  input logic             wr_take,
  input logic [1:0]       phase,
  input logic             rd_r,
  input logic [LIM_W-1:0] poll_cnt,
  input logic [LIM_W-1:0] lim_r
);
  localparam logic [1:0] PH_HDR = 2'd0, PH_POLL = 2'd1, PH_DATA = 2'd2;

  AST_IDLE_CS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> cs_n); // R3
  AST_SCK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sck); // R3
  AST_FRAME_START: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> (phase == PH_HDR && !sck)); // R3
  AST_POLL_MOSI_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && phase == PH_POLL) |-> !mosi); // R5
  AST_POLL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_POLL) |-> (poll_cnt <= lim_r)); // R7
  AST_READ_MOSI_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && phase == PH_DATA && rd_r) |-> !mosi); // R8
  AST_TAKE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |-> !rd_r); // R8
  AST_NOCAP_REFUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_flow && !cap_wait_poll) |=> (done && status == 2'd1 && cs_n)); // R9
  AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !(req_flow && !cap_wait_poll) && req_len == '0) |=> (done && status == 2'd0 && cs_n)); // R11
endmodule

bind tpm_spi_wait_engine tpm_spi_wait_engine_chk #(.LEN_W(LEN_W), .LIM_W(LIM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_flow(req_flow), .req_len(req_len), .cap_wait_poll(cap_wait_poll),
  .done(done), .status(status), .sck(sck), .cs_n(cs_n), .mosi(mosi),
  .wr_take(wr_take), .phase(phase), .rd_r(rd_r), .poll_cnt(poll_cnt), .lim_r(lim_r)
);

// File: tb/tpm_spi_wait_engine_test.sv
`timescale 1ns/100ps
module tpm_spi_wait_engine_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_read = 1'b0, req_flow = 1'b0, cap_wait_poll = 1'b1;
  logic [15:0] req_addr = '0;
  logic [11:0] req_len = '0;
  logic [7:0]  wr_data = '0, poll_limit = '0;
  logic req_ready, wr_take, rd_valid, poll_armed, done, sck, cs_n, mosi;
  logic [7:0] rd_data;
  logic [1:0] status;
  logic miso = 1'b0;

  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  tpm_spi_wait_engine uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_read(req_read), .req_flow(req_flow), .req_addr(req_addr), .req_len(req_len),
    .wr_data(wr_data), .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid),
    .cap_wait_poll(cap_wait_poll), .poll_limit(poll_limit), .poll_armed(poll_armed),
    .done(done), .status(status), .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso));

  function automatic logic [7:0] wval(int k); return 8'(k * 13 + 5); endfunction
  function automatic logic [7:0] rval(int k); return 8'(k * 29 + 17); endfunction

  // target model
  logic t_flow = 1'b0, t_rd = 1'b0;
  int   t_wait = 0;
  int   bitn = 0, nframes = 0, wn = 0, t_ridx = 0, poll_bad = 0, rdmosi_bad = 0;
  logic [7:0] sh_in = '0;
  logic [7:0] hdr_log [0:63][0:3];
  int   fbits [0:63];
  logic [7:0] wlog [0:511];

  function automatic logic tgt_bit(int n);
    int d0;
    logic [7:0] b;
    d0 = 32 + (t_flow ? 8 * t_wait : 0);
    if (n < 31) return 1'b0;
    if (n == 31) return (t_wait == 0);
    if (n < d0) return (((n - 32) % 8) == 7) && (((n - 32) / 8) == t_wait - 1);
    if (!t_rd) return 1'b0;
    b = rval(t_ridx);
    return b[7 - ((n - d0) % 8)];
  endfunction

  always @(posedge sck or posedge cs_n) begin
    if (cs_n) begin
      if (nframes < 64) fbits[nframes] = bitn;
      nframes = nframes + 1;
      bitn = 0;
    end else begin
      sh_in = {sh_in[6:0], mosi};
      bitn = bitn + 1;
      if (bitn % 8 == 0) begin
        if (bitn / 8 - 1 < 4) begin
          if (nframes < 64) hdr_log[nframes][bitn / 8 - 1] = sh_in;
        end else if (t_flow && (bitn / 8 - 5) < t_wait) begin
          if (sh_in != 8'h00) poll_bad = poll_bad + 1;
        end else if (t_rd) begin
          if (sh_in != 8'h00) rdmosi_bad = rdmosi_bad + 1;
          t_ridx = t_ridx + 1;
        end else begin
          if (wn < 512) wlog[wn] = sh_in;
          wn = wn + 1;
        end
      end
    end
  end

  always @(negedge cs_n or negedge sck) if (!cs_n) miso = tgt_bit(bitn);

  task automatic check(input logic ok, input string req, input string what, input int act, input int exp);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  typedef struct packed {
    logic rd; logic flow; logic cap; logic [15:0] addr; logic [11:0] len;
    logic [7:0] waitn; logic [7:0] lim; logic [1:0] exp;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b1, 1'b1, 16'h0F24, 12'd4,   8'd0, 8'd8, 2'd0},
    '{1'b0, 1'b1, 1'b1, 16'hA55A, 12'd3,   8'd2, 8'd8, 2'd0},
    '{1'b1, 1'b1, 1'b1, 16'h1234, 12'd70,  8'd1, 8'd4, 2'd0},
    '{1'b0, 1'b1, 1'b1, 16'h00FF, 12'd130, 8'd0, 8'd4, 2'd0},
    '{1'b1, 1'b1, 1'b1, 16'h7E01, 12'd100, 8'd5, 8'd3, 2'd2},
    '{1'b0, 1'b1, 1'b1, 16'h4321, 12'd1,   8'd4, 8'd0, 2'd2},
    '{1'b0, 1'b0, 1'b1, 16'hBEEF, 12'd2,   8'd3, 8'd8, 2'd0},
    '{1'b1, 1'b1, 1'b0, 16'h0001, 12'd8,   8'd0, 8'd8, 2'd1},
    '{1'b0, 1'b1, 1'b1, 16'h0002, 12'd0,   8'd0, 8'd8, 2'd0},
    '{1'b1, 1'b1, 1'b1, 16'hC0DE, 12'd64,  8'd3, 8'd3, 2'd0}
  };

  task automatic run_vec(input vec_t v);
    int fbase, wbase, rbase, pbase, mbase, nf_exp, widx, ridx, rbad, guard, len, fs, bits_exp;
    string tag;
    len = int'(v.len);
    tag = (v.exp == 2'd1) ? "R9" : (v.exp == 2'd2) ? "R7" : (len == 0) ? "R11" :
          (!v.flow) ? "R10" : (v.waitn != 0) ? "R5" : "R6";
    nf_exp = (v.exp == 2'd1 || len == 0) ? 0 : (v.exp == 2'd2) ? 1 : (len + 63) / 64;
    @(negedge clk);
    t_flow = v.flow; t_rd = v.rd; t_wait = int'(v.waitn);
    fbase = nframes; wbase = wn; rbase = t_ridx; pbase = poll_bad; mbase = rdmosi_bad;
    widx = 0; ridx = 0; rbad = 0; guard = 0;
    wr_data = wval(0);
    req_read = v.rd; req_flow = v.flow; cap_wait_poll = v.cap; req_addr = v.addr;
    req_len = v.len; poll_limit = v.lim; req_valid = 1'b1;
    do begin
      @(negedge clk);
      req_valid = 1'b0;
      guard = guard + 1;
      if (wr_take) begin widx = widx + 1; wr_data = wval(widx); end
      if (rd_valid) begin
        if (rd_data != rval(rbase + ridx)) rbad = rbad + 1;
        ridx = ridx + 1;
      end
    end while (!done && guard < 40000);
    check(status == v.exp, tag, "status", int'(status), int'(v.exp));
    check(cs_n && !sck, "R3", "bus parked after done", int'({cs_n, sck}), 2);
    repeat (3) @(negedge clk);
    check(nframes - fbase == nf_exp, "R4", "frame count", nframes - fbase, nf_exp);
    for (int f = 0; f < nf_exp && f < 8 && (fbase + f) < 64; f++) begin
      fs = (len - 64 * f > 64) ? 64 : len - 64 * f;
      check(hdr_log[fbase + f][0] == {v.rd, 1'b0, 6'(fs - 1)}, "R1", "header byte 0",
            int'(hdr_log[fbase + f][0]), int'({v.rd, 1'b0, 6'(fs - 1)}));
      check(hdr_log[fbase + f][1] == 8'hD4 && hdr_log[fbase + f][2] == v.addr[15:8] &&
            hdr_log[fbase + f][3] == v.addr[7:0], "R2", "header bytes 1..3",
            int'({hdr_log[fbase + f][1], hdr_log[fbase + f][2], hdr_log[fbase + f][3]}),
            int'({8'hD4, v.addr}));
      bits_exp = (v.exp == 2'd2) ? 32 + 8 * int'(v.lim)
               : 32 + (v.flow ? 8 * int'(v.waitn) : 0) + 8 * fs;
      check(fbits[fbase + f] == bits_exp, tag, "frame bits", fbits[fbase + f], bits_exp);
    end
    if (v.exp == 2'd0 && len > 0) begin
      if (v.rd) begin
        check(ridx == len && rbad == 0, "R8", "read bytes returned", ridx - rbad, len);
        check(rdmosi_bad == mbase, "R8", "mosi high in read data", rdmosi_bad - mbase, 0);
      end else begin
        rbad = 0;
        for (int k = 0; k < len; k++) if (wlog[wbase + k] != wval(k)) rbad = rbad + 1;
        check(wn - wbase == len && rbad == 0 && ridx == 0, "R8", "write bytes on bus",
              wn - wbase - rbad, len);
      end
    end
    if (v.exp == 2'd2) check(ridx == 0 && widx == 0, "R7", "no data after timeout", ridx + widx, 0);
    check(poll_bad == pbase, "R5", "mosi high in poll byte", poll_bad - pbase, 0);
    if (v.exp != 2'd1) check(poll_armed == v.flow, "R10", "poll_armed", int'(poll_armed), int'(v.flow));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(cs_n && !sck && !done && !poll_armed && req_ready, "R12", "reset state",
          int'({cs_n, sck, done, poll_armed, req_ready}), 5'b10001);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) run_vec(VEC[i]);
    // reset in the middle of a frame
    @(negedge clk);
    t_flow = 1'b1; t_rd = 1'b1; t_wait = 0;
    req_read = 1'b1; req_flow = 1'b1; cap_wait_poll = 1'b1; req_addr = 16'h2222;
    req_len = 12'd70; poll_limit = 8'd4; req_valid = 1'b1;
    @(negedge clk); req_valid = 1'b0;
    repeat (200) @(negedge clk);
    check(!cs_n && !req_ready, "R3", "frame in progress", int'(cs_n), 0);
    rst_n = 1'b0;
    @(negedge clk);
    check(cs_n && !sck && !done && !poll_armed && req_ready, "R12", "mid-frame reset",
          int'({cs_n, sck, done, poll_armed, req_ready}), 5'b10001);
    rst_n = 1'b1;
    run_vec(VEC[1]);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests = tests + 1;
    fails = fails + 1;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule